// File: doc/BRIEF.md
# Time-Stamping Pixel Matrix with Zero-Skip Readout

This block models the digital side of a matrix of particle-sensing pixels. The matrix has two phases. During an acquisition window (one bunch train), every pixel watches its own hit strobe. On each rising edge of the strobe, the pixel copies the current value of a shared time-stamp counter into a two-entry local store. A write pointer then moves to the second entry. A pixel that is hit a third time or more keeps its first two stamps and raises an overflow flag.

Readout runs between trains. The scanner walks the pixels from the lowest linear address (row-major, `row*COLS+col`) to the highest and emits one record per stored stamp. Each record carries the pixel address, the stamp and the overflow flag, and leaves the block on a valid/ready handshake. A one-cycle priority search over the per-pixel occupancy flags finds the next occupied pixel, so empty pixels take no readout cycles. A pixel clears itself once its last record has been accepted, which leaves the matrix empty for the next train.

The default build is 16 x 16 pixels with a 14-bit stamp. The dimensions are parameters, so the full-size 80 x 80 matrix (6400 addresses) is a parameter change.

Top module: `ts_pixel_array`

## Requirements
- R1: While `rst_n` is low and after it is released, `out_valid` and `rd_done` are 0 until a readout phase starts.
- R2: While `acq_en` is 1, a 0-to-1 transition of `hit[p]` seen at a clock edge stores the `ts_bus` value present at that edge in pixel p. A strobe held high stores only once. Rising edges two clock cycles apart are all taken, so one pixel sustains a stamp rate of half the clock.
- R3: A pixel's second capture in a train goes to its second entry. Readout emits the first-captured stamp before the second.
- R4: A capture attempt on a pixel whose two entries are full is dropped and sets that pixel's overflow flag. Every record of that pixel then carries `out_ovf` = 1. Pixels with at most two hits carry `out_ovf` = 0.
- R5: Hit strobes have no effect while `acq_en` is 0.
- R6: Readout is active in each cycle that follows a clock edge at which `rd_en` was 1 and `acq_en` was 0. Records come out in ascending address order. Empty pixels are skipped, so with `out_ready` held at 1, `out_valid` stays at 1 on consecutive cycles until the last record is accepted.
- R7: `rd_done` is 1 in the cycle after the last record is accepted. It is also 1 in the first active readout cycle when no pixel holds a stamp. `rd_done` and `out_valid` are never 1 together.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_addr`, `out_stamp` and `out_ovf` keep their values and `out_valid` stays at 1.
- R9: Once its last record is accepted, a pixel's entries, pointer and overflow flag clear. A repeated readout then finds nothing, and the next train starts from an empty matrix.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hit | input | ROWS*COLS | Per-pixel hit strobe; bit index is the linear address |
| ts_bus | input | TS_W | Shared time-stamp count |
| acq_en | input | 1 | Acquisition window (bunch train) active |
| rd_en | input | 1 | Readout phase request |
| out_ready | input | 1 | Downstream accepts the current record |
| out_valid | output | 1 | A record is presented |
| out_addr | output | $clog2(ROWS*COLS) | Linear address of the pixel in the record |
| out_stamp | output | TS_W | Stored time stamp |
| out_ovf | output | 1 | Pixel saw more hits than it could store |
| rd_done | output | 1 | Readout active and no stored stamp remains |

## Verification
The bench runs a 4 x 4 matrix through several trains. In each train, every pixel receives from zero to four hits, following a count pattern that shifts from train to train. These trains exercise the empty, single, double and overflowing pixel cases side by side, and adjacent occupied and empty addresses. A scanner that spends a cycle on an empty pixel, swaps the order of the two stamps, or loses the overflow flag on the first record would emit a record out of order, emit a wrong value, or drop `out_valid` in a cycle where the bench expects a record. Stalled handshakes, held strobes, hits outside the window, an all-empty readout and a repeated readout each catch, in turn: a multiplexer that moves under back-pressure, a level-triggered capture, a leaked capture, a late done flag, and a pixel that does not clear.

// File: rtl/ts_pkg.sv
// Package: shared constants and types for the time-stamping pixel matrix.
// Assumes each pixel stores exactly two stamps, so a 2-bit count is enough.
package ts_pkg;
    localparam int SLOTS = 2;
    localparam int CNT_W = 2;
    typedef logic [CNT_W-1:0] fill_t;
    localparam fill_t FILL_NONE = 2'd0;
    localparam fill_t FILL_ONE  = 2'd1;
    localparam fill_t FILL_TWO  = 2'd2;
endpackage

// File: rtl/ts_pixel_cell.sv
// Module: one pixel's digital store.
// Detects a rising edge on the hit strobe. While capture is enabled, it writes
// the shared stamp into the next free entry of a two-entry store, or sets the
// overflow flag when both entries are full. A clear request empties the store.
// Assumes hit is already synchronous to clk.
module ts_pixel_cell
    import ts_pkg::*;
#(
    parameter int TS_W = 14
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hit,
    input  logic            cap_en,
    input  logic [TS_W-1:0] ts_bus,
    input  logic            clr,
    output fill_t           fill,
    output logic [TS_W-1:0] stamp0,
    output logic [TS_W-1:0] stamp1,
    output logic            ovf
);
    logic hit_q;
    logic rise;

    assign rise = hit && !hit_q;

    // Purpose: remember last strobe level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) hit_q <= 1'b0;
        else        hit_q <= hit;
    end

    // Purpose: capture stamps, advance pointer, flag overflow, clear after readout.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            fill   <= FILL_NONE;
            stamp0 <= '0;
            stamp1 <= '0;
            ovf    <= 1'b0;
        end else if (rise && cap_en) begin
            case (fill)
                FILL_NONE: begin
                    stamp0 <= ts_bus;
                    fill   <= FILL_ONE;
                end
                FILL_ONE: begin
                    stamp1 <= ts_bus;
                    fill   <= FILL_TWO;
                end
                default: ovf <= 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/ts_first_set.sv
// Module: single-cycle priority search.
// Returns the lowest index whose bit is set, and whether any bit is set.
// Pure combinational; assumes N >= 1 and AW wide enough for N-1.
module ts_first_set #(
    parameter int N  = 256,
    parameter int AW = 8
) (
    input  logic [N-1:0]  vec,
    output logic [AW-1:0] idx,
    output logic          any
);
    // Purpose: scan from the top so the lowest set bit wins.
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = AW'(i);
        end
    end

    assign any = |vec;
endmodule

// File: rtl/ts_readout_ctl.sv
// Module: readout sequencer.
// Tracks the readout phase, picks which of the two entries of the selected
// pixel is presented, runs the valid/ready handshake, and requests a clear
// when a pixel's last record is accepted. Assumes the selected pixel stays
// the lowest occupied one until it is cleared (no captures during readout).
module ts_readout_ctl
    import ts_pkg::*;
#(
    parameter int AW   = 8,
    parameter int TS_W = 14
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rd_en,
    input  logic            acq_en,
    input  logic            any_occ,
    input  logic [AW-1:0]   sel_idx,
    input  fill_t           sel_fill,
    input  logic [TS_W-1:0] sel_stamp0,
    input  logic [TS_W-1:0] sel_stamp1,
    input  logic            sel_ovf,
    input  logic            out_ready,
    output logic            out_valid,
    output logic [AW-1:0]   out_addr,
    output logic [TS_W-1:0] out_stamp,
    output logic            out_ovf,
    output logic            rd_done,
    output logic            clr_go,
    output logic            run
);
    logic second;
    logic fire;
    logic last_rec;

    assign out_valid = run && any_occ;
    assign rd_done   = run && !any_occ;
    assign fire      = out_valid && out_ready;
    assign last_rec  = second || (sel_fill == FILL_ONE);
    assign clr_go    = fire && last_rec;
    assign out_addr  = sel_idx;
    assign out_stamp = second ? sel_stamp1 : sel_stamp0;
    assign out_ovf   = sel_ovf;

    // Purpose: readout phase flag, active only between trains.
    always_ff @(posedge clk) begin
        if (!rst_n) run <= 1'b0;
        else        run <= rd_en && !acq_en;
    end

    // Purpose: select first or second entry of the current pixel.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) second <= 1'b0;
        else if (fire)      second <= !last_rec;
    end
endmodule

// File: rtl/ts_pixel_array.sv
// Module: top of the time-stamping pixel matrix.
// Instantiates ROWS*COLS pixel cells (linear address row*COLS+col), a
// priority search over their occupancy, and the readout sequencer. Captures
// are allowed only while acq_en is high and readout is idle.
module ts_pixel_array
    import ts_pkg::*;
#(
    parameter int  ROWS = 16,
    parameter int  COLS = 16,
    parameter int  TS_W = 14,
    localparam int NPIX = ROWS * COLS,
    localparam int AW   = (NPIX > 1) ? $clog2(NPIX) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIX-1:0] hit,
    input  logic [TS_W-1:0] ts_bus,
    input  logic            acq_en,
    input  logic            rd_en,
    input  logic            out_ready,
    output logic            out_valid,
    output logic [AW-1:0]   out_addr,
    output logic [TS_W-1:0] out_stamp,
    output logic            out_ovf,
    output logic            rd_done
);
    fill_t           fill_a   [NPIX];
    logic [TS_W-1:0] stamp0_a [NPIX];
    logic [TS_W-1:0] stamp1_a [NPIX];
    logic [NPIX-1:0] ovf_v;
    logic [NPIX-1:0] occ_v;
    logic [NPIX-1:0] clr_v;
    logic [AW-1:0]   sel_idx;
    logic            any_occ;
    logic            clr_go;
    logic            run;
    logic            cap_en;

    assign cap_en = acq_en && !run;

    for (genvar p = 0; p < NPIX; p++) begin : g_pix
        ts_pixel_cell #(.TS_W(TS_W)) cell_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .hit    (hit[p]),
            .cap_en (cap_en),
            .ts_bus (ts_bus),
            .clr    (clr_v[p]),
            .fill   (fill_a[p]),
            .stamp0 (stamp0_a[p]),
            .stamp1 (stamp1_a[p]),
            .ovf    (ovf_v[p])
        );
        assign occ_v[p] = (fill_a[p] != FILL_NONE);
        assign clr_v[p] = clr_go && (sel_idx == AW'(p));
    end

    ts_first_set #(.N(NPIX), .AW(AW)) search_i (
        .vec (occ_v),
        .idx (sel_idx),
        .any (any_occ)
    );

    ts_readout_ctl #(.AW(AW), .TS_W(TS_W)) ctl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_en      (rd_en),
        .acq_en     (acq_en),
        .any_occ    (any_occ),
        .sel_idx    (sel_idx),
        .sel_fill   (fill_a[sel_idx]),
        .sel_stamp0 (stamp0_a[sel_idx]),
        .sel_stamp1 (stamp1_a[sel_idx]),
        .sel_ovf    (ovf_v[sel_idx]),
        .out_ready  (out_ready),
        .out_valid  (out_valid),
        .out_addr   (out_addr),
        .out_stamp  (out_stamp),
        .out_ovf    (out_ovf),
        .rd_done    (rd_done),
        .clr_go     (clr_go),
        .run        (run)
    );
endmodule

// File: rtl/ts_pixel_array_chk.sv
// Module: property checker for ts_pixel_array, attached through bind.
// Observes only the top-level ports.
module ts_pixel_array_chk #(
    parameter int AW   = 8,
    parameter int TS_W = 14
) (
    input logic            clk,
    input logic            rst_n,
    input logic            acq_en,
    input logic            rd_en,
    input logic            out_ready,
    input logic            out_valid,
    input logic [AW-1:0]   out_addr,
    input logic [TS_W-1:0] out_stamp,
    input logic            out_ovf,
    input logic            rd_done
);
    AST_HOLD_WHEN_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_stamp) && $stable(out_ovf)); // R8

    AST_DONE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |-> !out_valid); // R7

    AST_VALID_IN_READOUT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(rd_en && !acq_en)); // R6

    AST_ADDR_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready |=> !out_valid || (out_addr >= $past(out_addr))); // R6

    AST_DONE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done && rd_en && !acq_en |=> rd_done); // R9
endmodule

bind ts_pixel_array ts_pixel_array_chk #(.AW(AW), .TS_W(TS_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .acq_en    (acq_en),
    .rd_en     (rd_en),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_addr  (out_addr),
    .out_stamp (out_stamp),
    .out_ovf   (out_ovf),
    .rd_done   (rd_done)
);

// File: tb/ts_pixel_array_tb_top.sv
// Bench: 4x4 matrix, trains with arithmetic hit patterns, readout compared
// against a model kept in the bench.
module ts_pixel_array_tb_top;
    localparam int ROWS = 4;
    localparam int COLS = 4;
    localparam int TS_W = 14;
    localparam int NP   = ROWS * COLS;
    localparam int AW   = $clog2(NP);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NP-1:0]   hit = '0;
    logic [TS_W-1:0] ts_bus = '0;
    logic            acq_en = 1'b0;
    logic            rd_en = 1'b0;
    logic            out_ready = 1'b0;
    logic            out_valid;
    logic [AW-1:0]   out_addr;
    logic [TS_W-1:0] out_stamp;
    logic            out_ovf;
    logic            rd_done;

    int n_chk = 0;
    int n_bad = 0;

    int          e_cnt [NP];
    int          e_st  [NP][2];
    bit          e_ovf [NP];

    always #10 clk = ~clk;

    ts_pixel_array #(.ROWS(ROWS), .COLS(COLS), .TS_W(TS_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .hit(hit), .ts_bus(ts_bus),
        .acq_en(acq_en), .rd_en(rd_en), .out_ready(out_ready),
        .out_valid(out_valid), .out_addr(out_addr), .out_stamp(out_stamp),
        .out_ovf(out_ovf), .rd_done(rd_done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int p = 0; p < NP; p++) begin
            e_cnt[p] = 0; e_st[p][0] = 0; e_st[p][1] = 0; e_ovf[p] = 1'b0;
        end
    endtask

    task automatic model_hit(input int p, input int ts);
        if (e_cnt[p] < 2) begin
            e_st[p][e_cnt[p]] = ts;
            e_cnt[p]++;
        end else begin
            e_ovf[p] = 1'b1;
        end
    endtask

    // One train: pixel p gets (p*7+t*3)%5 single-cycle pulses, spaced two cycles.
    task automatic run_train(input int t, input bit acq);
        @(negedge clk);
        acq_en = acq;
        for (int k = 0; k < 4; k++) begin
            logic [NP-1:0] m;
            int ts;
            m  = '0;
            ts = (t * 256 + k * 16 + 3) % (1 << TS_W);
            for (int p = 0; p < NP; p++) begin
                if (k < (p * 7 + t * 3) % 5) begin
                    m[p] = 1'b1;
                    if (acq) model_hit(p, ts);
                end
            end
            @(negedge clk);
            hit = m;
            ts_bus = TS_W'(ts);
            @(negedge clk);
            hit = '0;
            ts_bus = TS_W'(ts + 1);
        end
        @(negedge clk);
        acq_en = 1'b0;
    endtask

    // Readout compared record by record; stall pattern when stall=1.
    task automatic do_readout(input bit stall, input string tag);
        int q_a [2*NP];
        int q_s [2*NP];
        bit q_o [2*NP];
        int n = 0;
        int idx = 0;
        int cyc = 0;
        for (int p = 0; p < NP; p++) begin
            for (int s = 0; s < e_cnt[p]; s++) begin
                q_a[n] = p; q_s[n] = e_st[p][s]; q_o[n] = e_ovf[p]; n++;
            end
        end
        @(negedge clk);
        rd_en = 1'b1;
        out_ready = 1'b0;
        @(negedge clk);
        while (idx < n) begin
            // R6 R3 R4: next record in ascending order, no idle cycle
            chk(out_valid === 1'b1, "R6", {tag, " valid"}, out_valid, 1);
            chk(out_addr === AW'(q_a[idx]), "R6", {tag, " addr"}, out_addr, q_a[idx]);
            chk(out_stamp === TS_W'(q_s[idx]), "R3", {tag, " stamp"}, out_stamp, q_s[idx]);
            chk(out_ovf === q_o[idx], "R4", {tag, " ovf"}, out_ovf, q_o[idx]);
            chk(rd_done === 1'b0, "R7", {tag, " done early"}, rd_done, 0);
            out_ready = stall ? (cyc % 3 != 0) : 1'b1;  // R8 stall cycles
            if (out_ready) idx++;
            cyc++;
            @(negedge clk);
        end
        chk(rd_done === 1'b1, "R7", {tag, " done after last"}, rd_done, 1);
        chk(out_valid === 1'b0, "R7", {tag, " valid after last"}, out_valid, 0);
        model_clear();
        out_ready = 1'b1;
        @(negedge clk);
        chk(rd_done === 1'b1 && out_valid === 1'b0, "R9", {tag, " stays empty"}, out_valid, 0);
        rd_en = 1'b0;
        out_ready = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        model_clear();
        repeat (3) @(negedge clk);
        chk(out_valid === 1'b0, "R1", "valid in reset", out_valid, 0);
        chk(rd_done === 1'b0, "R1", "done in reset", rd_done, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(out_valid === 1'b0 && rd_done === 1'b0, "R1", "after reset", out_valid, 0);

        // R7: empty matrix, done in first readout cycle
        do_readout(1'b0, "empty");

        // R2 R3 R4 R6 R8 R9: sweep of trains, alternating stall
        for (int t = 0; t < 6; t++) begin
            run_train(t, 1'b1);
            do_readout(t[0], "train");
        end

        // R5: hits outside the window are ignored
        run_train(2, 1'b0);
        do_readout(1'b0, "r5_no_acq");

        // R2: held strobe captures once; pixel 6 pulses twice two cycles apart
        @(negedge clk);
        acq_en = 1'b1;
        @(negedge clk);
        hit[5] = 1'b1; hit[6] = 1'b1; ts_bus = 14'd100;
        model_hit(5, 100); model_hit(6, 100);
        @(negedge clk);
        hit[6] = 1'b0; ts_bus = 14'd101;
        @(negedge clk);
        hit[6] = 1'b1; ts_bus = 14'd102;
        model_hit(6, 102);
        @(negedge clk);
        hit = '0; ts_bus = 14'd103;
        @(negedge clk);
        acq_en = 1'b0;
        do_readout(1'b1, "r2_level");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule